// File: doc/BRIEF.md
# Differential snapshot register bank

This block is a behavioural model of a state register bank in which every bit is held twice: once on a true rail and once, inverted, on a complement rail. Both rails are rising-edge flip-flops with an asynchronous clear. Each bit also has a shared backup slot that models nonvolatile storage. The backup slot keeps both rails and has no reset, so its contents survive a simulated power loss that clears the flip-flops.

A small controller produces the two strobes that move data between the rails and the backup slot. A save request can come from the datapath (`save_req`) or from an external pin (`pin_save`) that is used before power-off. The save request starts a delay of `WR_DELAY` clock cycles, so that the registers have settled before they are captured. The controller then raises a one-cycle write strobe. A restore can only come from the external pin `pin_restore`. The controller samples this pin only at the falling clock edge, which is the start of the low phase. The restore then takes effect at the next rising edge.

The save controller is a three-state machine. From `SV_IDLE` it moves to `SV_HOLD` on any save request. `SV_HOLD` counts `WR_DELAY` cycles and then goes to `SV_WRITE`. `SV_WRITE` asserts the write strobe for one cycle and returns to `SV_IDLE`.

Top module: `dsnap_bank`

## Requirements
- R1: On a rising edge with `reg_en` high and no restore pending, `q_true` takes `d_in` and `q_comp` takes `~d_in`.
- R2: While `rst_n` is low, `q_true` and `q_comp` are both all zeros, whatever the state of the clock.
- R3: A save request is `save_req` or `pin_save` high at a rising edge while the controller is in `SV_IDLE`. It produces exactly one write strobe, which copies both rails into the backup slot, and the two backup rails are opposite.
- R4: If a request is seen at edge k, the backup captures the rail values present after edge k+`WR_DELAY` (default 2). Those values are committed at edge k+`WR_DELAY`+1.
- R5: If `pin_restore` is high at a falling edge, then at the next rising edge both rails are loaded from the backup slot.
- R6: A `pin_restore` pulse that rises and falls within the high phase of the clock has no effect on the rails.
- R7: The backup contents are not cleared by `rst_n`. A restore after a reset returns the value saved before the reset.
- R8: With `reg_en` low, both rails hold their value. A restore still loads the rails while `reg_en` is low.
- R9: `pin_save` alone starts a save in the same way as `save_req`.
- R10: Save requests that arrive while a save is in progress (`SV_HOLD` or `SV_WRITE`) are ignored and start no second write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; rails update on the rising edge, restore requests are sampled on the falling edge |
| rst_n | input | 1 | Asynchronous active-low clear of the rails and the controller (simulated power loss) |
| reg_en | input | 1 | Register enable for both rails |
| d_in | input | WIDTH | Next state value |
| save_req | input | 1 | Save request from the datapath |
| pin_save | input | 1 | External save pin |
| pin_restore | input | 1 | External restore pin |
| q_true | output | WIDTH | True rail |
| q_comp | output | WIDTH | Complement rail |

## Verification
If the backup slot captures at the wrong cycle, the fault appears only after a later restore. The restored `q_true` then shows a value from a neighbouring cycle of the save window, so the bench changes `d_in` on every cycle of that window. A corrupted rail pairing shows at once, one edge after a load, as `q_comp` differing from `~q_true`. An error in restore qualification appears at the rising edge after the offending high-phase pulse, as a rail value that changed with no legitimate request.

// File: rtl/dsnap_pkg.sv
package dsnap_pkg;
    typedef enum logic [1:0] {
        SV_IDLE  = 2'd0,
        SV_HOLD  = 2'd1,
        SV_WRITE = 2'd2
    } sv_state_t;
endpackage

// File: rtl/dsnap_ctrl.sv
module dsnap_ctrl
    import dsnap_pkg::*;
#(
    parameter int WR_DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic save_req,
    input  logic pin_save,
    input  logic pin_restore,
    output logic wr_stb,
    output logic rd_go
);
    localparam int CW = (WR_DELAY > 1) ? $clog2(WR_DELAY) : 1;
    localparam logic [CW-1:0] LAST = CW'(WR_DELAY - 1);

    sv_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic any_save;
    logic arm_q;

    assign any_save = save_req | pin_save;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SV_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SV_IDLE: begin
                cnt_d = '0;
                if (any_save) state_d = SV_HOLD;
            end
            SV_HOLD: begin
                if (cnt_q == LAST) begin
                    state_d = SV_WRITE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SV_WRITE: state_d = SV_IDLE;
            default:  state_d = SV_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_stb = 1'b0;
        unique case (state_q)
            SV_WRITE: wr_stb = 1'b1;
            default:  wr_stb = 1'b0;
        endcase
    end

    // restore qualification: sampled as the clock enters its low phase
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= pin_restore;
    end

    assign rd_go = arm_q;
endmodule

// File: rtl/dsnap_cell.sv
module dsnap_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic d,
    input  logic wr_stb,
    input  logic rd_go,
    output logic q_t,
    output logic q_c,
    output logic bk_t,
    output logic bk_c
);
    // differential rails
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_t <= 1'b0;
            q_c <= 1'b0;
        end else if (rd_go) begin
            q_t <= bk_t;
            q_c <= bk_c;
        end else if (en) begin
            q_t <= d;
            q_c <= ~d;
        end
    end

    // backup slot: no reset, models retention across power loss
    always_ff @(posedge clk) begin
        if (wr_stb) begin
            bk_t <= q_t;
            bk_c <= q_c;
        end
    end
endmodule

// File: rtl/dsnap_bank.sv
module dsnap_bank #(
    parameter int WIDTH    = 8,
    parameter int WR_DELAY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_en,
    input  logic [WIDTH-1:0] d_in,
    input  logic             save_req,
    input  logic             pin_save,
    input  logic             pin_restore,
    output logic [WIDTH-1:0] q_true,
    output logic [WIDTH-1:0] q_comp
);
    logic             wr_stb;
    logic             rd_go;
    logic [WIDTH-1:0] bk_t;
    logic [WIDTH-1:0] bk_c;

    dsnap_ctrl #(.WR_DELAY(WR_DELAY)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .save_req   (save_req),
        .pin_save   (pin_save),
        .pin_restore(pin_restore),
        .wr_stb     (wr_stb),
        .rd_go      (rd_go)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        dsnap_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (reg_en),
            .d     (d_in[i]),
            .wr_stb(wr_stb),
            .rd_go (rd_go),
            .q_t   (q_true[i]),
            .q_c   (q_comp[i]),
            .bk_t  (bk_t[i]),
            .bk_c  (bk_c[i])
        );
    end
endmodule

// File: rtl/dsnap_bank_chk.sv
module dsnap_bank_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_en,
    input logic [WIDTH-1:0] q_true,
    input logic [WIDTH-1:0] q_comp,
    input logic             wr_stb,
    input logic             rd_go,
    input logic [WIDTH-1:0] bk_t,
    input logic [WIDTH-1:0] bk_c
);
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEARS: assert (q_true == '0 && q_comp == '0); // R2
        end
    end

    AST_RAILS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !rd_go) |=> (q_comp == ~q_true)); // R1

    AST_BACKUP_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (q_comp == ~q_true)) |=> (bk_c == ~bk_t)); // R3

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R10

    AST_RESTORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !wr_stb) |=> (q_true == $past(bk_t) && q_comp == $past(bk_c))); // R5

    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_en && !rd_go) |=> ($stable(q_true) && $stable(q_comp))); // R8
endmodule

bind dsnap_bank dsnap_bank_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .reg_en(reg_en),
    .q_true(q_true),
    .q_comp(q_comp),
    .wr_stb(wr_stb),
    .rd_go (rd_go),
    .bk_t  (bk_t),
    .bk_c  (bk_c)
);

// File: tb/tb_dsnap_bank.sv
module tb_dsnap_bank;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_en = 1'b0;
    logic [W-1:0] d_in = '0;
    logic         save_req = 1'b0;
    logic         pin_save = 1'b0;
    logic         pin_restore = 1'b0;
    logic [W-1:0] q_true, q_comp;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsnap_bank #(.WIDTH(W), .WR_DELAY(2)) dut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .d_in(d_in),
        .save_req(save_req), .pin_save(pin_save), .pin_restore(pin_restore),
        .q_true(q_true), .q_comp(q_comp)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_q(string req, logic [W-1:0] et, logic [W-1:0] ec);
        checks++;
        if (q_true !== et || q_comp !== ec) begin
            errors++;
            $display("FAIL %s: q_true=%h q_comp=%h expected %h %h", req, q_true, q_comp, et, ec);
        end
    endtask

    task automatic load(logic [W-1:0] v);
        d_in = v; reg_en = 1'b1;
        step();
        reg_en = 1'b0;
    endtask

    task automatic restore();
        pin_restore = 1'b1;
        step();
        pin_restore = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #(CLK_PERIOD*2 + 3);
        expect_q("R2 in reset", '0, '0);
        step();
        rst_n = 1'b1;
        step();
        expect_q("R2 after release", '0, '0);
    endtask

    task automatic t_load();
        logic [W-1:0] pats [3] = '{8'hA5, 8'h00, 8'hFF};
        for (int i = 0; i < 3; i++) begin
            load(pats[i]);
            expect_q("R1 load", pats[i], ~pats[i]);
        end
    endtask

    task automatic t_hold();
        load(8'h3C);
        d_in = 8'hC3;
        step(); step(); step();
        expect_q("R8 hold with reg_en low", 8'h3C, 8'hC3);
    endtask

    task automatic t_save_delay();
        // edge k: A, request; edge k+1: B, repeated request (R10); edge k+2: C
        reg_en = 1'b1; d_in = 8'h11; save_req = 1'b1;
        step();
        d_in = 8'h22;
        step();
        save_req = 1'b0; d_in = 8'h33;
        step();
        reg_en = 1'b0;
        step();              // commit edge
        step(); step();
        load(8'h44);
        step(); step();
        restore();
        expect_q("R4 R3 R10 capture after delay", 8'h33, 8'hCC);
    endtask

    task automatic t_ignore_high();
        load(8'h5A);
        pin_restore = 1'b1;
        #2;
        pin_restore = 1'b0;
        step(); step();
        expect_q("R6 high-phase restore ignored", 8'h5A, 8'hA5);
    endtask

    task automatic t_power_loss();
        load(8'h96);
        save_req = 1'b1;
        step();
        save_req = 1'b0;
        step(); step(); step();
        load(8'h01);
        rst_n = 1'b0;
        #3;
        expect_q("R7 rails cleared by power loss", '0, '0);
        step();
        rst_n = 1'b1;
        step();
        restore();
        expect_q("R7 backup survives power loss", 8'h96, 8'h69);
    endtask

    task automatic t_pin_save();
        load(8'h7E);
        pin_save = 1'b1;
        step();
        pin_save = 1'b0;
        step(); step(); step();
        load(8'h0F);
        reg_en = 1'b0;
        restore();
        expect_q("R9 R8 pin save, restore with reg_en low", 8'h7E, 8'h81);
        step();
        expect_q("R5 single restore", 8'h7E, 8'h81);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        t_reset();
        t_load();
        t_hold();
        t_save_delay();
        t_ignore_high();
        t_power_loss();
        t_pin_save();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule